// File: doc/BRIEF.md
# 1-Wire Net Address Selection Handler

This block runs the device-selection phase of a 1-Wire slave. It sits above a link layer that has already turned bus waveforms into bit events. After each bus reset it takes in a command byte. It then either sends its identity, compares the identity the master sends, selects itself at once, or takes part in a binary-tree search. When the phase ends, the device is either handed to the function layer or parked until the next reset.

The 64-bit identity is put together inside the block. The family code, set by a parameter, fills bits 7:0. The serial number, taken from an input port, fills bits 55:8. A combinational CRC chain computes the top byte from the lower 56 bits. The link layer reports each master write slot with `wr_valid`/`wr_bit`. It reports each completed read slot with `rd_done`, and the bit it drove in that slot is the `tx_bit` the handler offered. A bus reset reaches the handler as `lnk_reset`.

Top module: `onewire_netaddr_sel`

## Requirements
- R1: After `rst_n` is released, `tx_en`, `selected` and `handoff` are 0, and the handler is waiting for a command byte.
- R2: Bits 7:0 of the identity are FAMILY_CODE (default 09h) and bits 55:8 are `serial_no`. Bits 63:56 are the CRC of bits 55:0 fed in from bit 0 upward, with polynomial x^8+x^5+x^4+1 and the register starting at 0.
- R3: The command byte is taken least significant bit first. Opcode 33h, and also 39h while ACCEPT_ALT_READ is 1, makes the handler offer the 64 identity bits from bit 0 upward, one per `rd_done`, with `tx_en` high. After the 64th read slot it becomes selected.
- R4: After opcode 55h the handler compares 64 written bits with its identity from bit 0 upward. If all of them agree, `selected` rises in the cycle after the event that carried the last bit.
- R5: After opcode 55h, a written bit that differs from the identity parks the handler. Further bit events leave `tx_en` and `selected` at 0 until `lnk_reset`.
- R6: Opcode CCh makes `selected` rise in the cycle after the event that carried the last command bit.
- R7: After opcode F0h, each identity bit i is handled in three slots: a read slot offering bit i, a read slot offering its complement, then a write slot. If the written bit equals bit i the handler moves on, and after bit 63 it becomes selected.
- R8: In a search, a written bit that differs from bit i parks the handler. From then until `lnk_reset`, `tx_en` stays 0 and no selection follows.
- R9: Any command byte other than 33h, 39h, 55h, CCh or F0h parks the handler until `lnk_reset`. In that state, a later CCh byte does not select it.
- R10: `lnk_reset` returns the handler to command reception from any state and clears `selected`. It wins over a bit event in the same cycle, so that event has no effect.
- R11: `handoff` is high for exactly one cycle: the first cycle in which `selected` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lnk_reset | input | 1 | Link layer saw a bus reset (one-cycle pulse) |
| wr_valid | input | 1 | Master write slot completed |
| wr_bit | input | 1 | Bit value of that write slot |
| rd_done | input | 1 | Read slot completed, with `tx_bit` driven on the bus |
| serial_no | input | SERIAL_W | Serial number field of the identity |
| tx_en | output | 1 | Handler wants to answer read slots |
| tx_bit | output | 1 | Bit to present in the next read slot (1 = release) |
| selected | output | 1 | Device selected, and the function layer owns the bus |
| handoff | output | 1 | One-cycle strobe when selection happens |

## Verification
A bus reset and the final bit event of a phase can arrive in the same cycle. Both want to move the state: one toward selection, the other back to command reception. The bench raises `lnk_reset` together with the 64th matching bit of a match command. It then checks that neither `selected` nor `handoff` appears, and that a following CCh byte is still decoded as a fresh command. Selection that lands in the same cycle as a reset is judged a failure. Selection after the later byte is judged a pass.

// File: rtl/onewire_netaddr_pkg.sv
package onewire_netaddr_pkg;

   localparam int FAM_W = 8;
   localparam int CRC_W = 8;
   localparam int CMD_W = 8;

   localparam logic [CMD_W-1:0] OPC_READ     = 8'h33;
   localparam logic [CMD_W-1:0] OPC_READ_ALT = 8'h39;
   localparam logic [CMD_W-1:0] OPC_MATCH    = 8'h55;
   localparam logic [CMD_W-1:0] OPC_SKIP     = 8'hCC;
   localparam logic [CMD_W-1:0] OPC_SEARCH   = 8'hF0;

   typedef enum logic [2:0] {
      K_NONE,
      K_READ,
      K_MATCH,
      K_SKIP,
      K_SEARCH
   } cmd_kind_t;

   typedef enum logic [2:0] {
      ST_CMD,
      ST_READ,
      ST_MATCH,
      ST_SRCH_T,
      ST_SRCH_C,
      ST_SRCH_W,
      ST_SEL,
      ST_PARK
   } sel_state_t;

endpackage

// File: rtl/netaddr_crc8_chain.sv
module netaddr_crc8_chain #(
   parameter int          NBITS = 56,
   parameter logic [7:0]  POLY_REFL = 8'h8C
) (
   input  logic [NBITS-1:0] data_in,
   output logic [7:0]       crc_out
);
   logic [7:0] stage [0:NBITS];

   assign stage[0] = 8'h00;

   for (genvar g = 0; g < NBITS; g++) begin : g_step
      logic fb;
      assign fb = stage[g][0] ^ data_in[g];
      assign stage[g+1] = {1'b0, stage[g][7:1]} ^ (fb ? POLY_REFL : 8'h00);
   end

   assign crc_out = stage[NBITS];
endmodule

// File: rtl/netaddr_opcode_dec.sv
module netaddr_opcode_dec
   import onewire_netaddr_pkg::*;
#(
   parameter bit ACCEPT_ALT_READ = 1'b1
) (
   input  logic [CMD_W-1:0] opcode,
   output cmd_kind_t        kind
);
   logic alt_hit;

   if (ACCEPT_ALT_READ) begin : g_alt_on
      assign alt_hit = (opcode == OPC_READ_ALT);
   end else begin : g_alt_off
      assign alt_hit = 1'b0;
   end

   always_comb begin
      if (opcode == OPC_READ || alt_hit) kind = K_READ;
      else if (opcode == OPC_MATCH)      kind = K_MATCH;
      else if (opcode == OPC_SKIP)       kind = K_SKIP;
      else if (opcode == OPC_SEARCH)     kind = K_SEARCH;
      else                               kind = K_NONE;
   end
endmodule

// File: rtl/netaddr_bit_ptr.sv
module netaddr_bit_ptr #(
   parameter int LIMIT = 64,
   localparam int CNT_W = $clog2(LIMIT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   output logic [CNT_W-1:0] idx,
   output logic             at_last
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      idx <= '0;
      else if (clr)    idx <= '0;
      else if (adv)    idx <= idx + 1'b1;
   end

   assign at_last = (idx == LAST);
endmodule

// File: rtl/onewire_netaddr_sel.sv
module onewire_netaddr_sel
   import onewire_netaddr_pkg::*;
#(
   parameter logic [7:0] FAMILY_CODE     = 8'h09,
   parameter int         SERIAL_W        = 48,
   parameter logic [7:0] CRC_POLY_REFL   = 8'h8C,
   parameter bit         ACCEPT_ALT_READ = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                lnk_reset,
   input  logic                wr_valid,
   input  logic                wr_bit,
   input  logic                rd_done,
   input  logic [SERIAL_W-1:0] serial_no,
   output logic                tx_en,
   output logic                tx_bit,
   output logic                selected,
   output logic                handoff
);
   localparam int BODY_W = FAM_W + SERIAL_W;
   localparam int ID_W   = BODY_W + CRC_W;
   localparam int CNT_W  = $clog2(ID_W);
   localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_W - 1);

   if (SERIAL_W < 8) begin : g_bad_serial
      $error("SERIAL_W must be at least 8");
   end
   if (ID_W > 256) begin : g_bad_id
      $error("identity wider than 256 bits is not supported");
   end

   logic [BODY_W-1:0] id_body;
   logic [CRC_W-1:0]  id_crc;
   logic [ID_W-1:0]   ident;

   assign id_body = {serial_no, FAMILY_CODE};

   netaddr_crc8_chain #(
      .NBITS     (BODY_W),
      .POLY_REFL (CRC_POLY_REFL)
   ) u_crc (
      .data_in (id_body),
      .crc_out (id_crc)
   );

   assign ident = {id_crc, id_body};

   logic             ptr_clr, ptr_adv, ptr_last;
   logic [CNT_W-1:0] idx;

   netaddr_bit_ptr #(.LIMIT(ID_W)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (ptr_clr),
      .adv     (ptr_adv),
      .idx     (idx),
      .at_last (ptr_last)
   );

   logic [CMD_W-2:0] cmd_sr;
   logic [CMD_W-1:0] opcode;
   cmd_kind_t        kind;

   assign opcode = {wr_bit, cmd_sr};

   netaddr_opcode_dec #(.ACCEPT_ALT_READ(ACCEPT_ALT_READ)) u_dec (
      .opcode (opcode),
      .kind   (kind)
   );

   sel_state_t st, st_nxt;
   logic       go_sel;
   logic       cur_bit;

   assign cur_bit = ident[idx];

   always_comb begin
      st_nxt  = st;
      ptr_clr = 1'b0;
      ptr_adv = 1'b0;
      go_sel  = 1'b0;
      if (lnk_reset) begin
         st_nxt  = ST_CMD;
         ptr_clr = 1'b1;
      end else begin
         unique case (st)
            ST_CMD: if (wr_valid) begin
               ptr_adv = 1'b1;
               if (idx == CMD_LAST) begin
                  ptr_clr = 1'b1;
                  unique case (kind)
                     K_READ:   st_nxt = ST_READ;
                     K_MATCH:  st_nxt = ST_MATCH;
                     K_SEARCH: st_nxt = ST_SRCH_T;
                     K_SKIP: begin
                        st_nxt = ST_SEL;
                        go_sel = 1'b1;
                     end
                     default:  st_nxt = ST_PARK;
                  endcase
               end
            end
            ST_READ: if (rd_done) begin
               ptr_adv = 1'b1;
               if (ptr_last) begin
                  ptr_clr = 1'b1;
                  st_nxt  = ST_SEL;
                  go_sel  = 1'b1;
               end
            end
            ST_MATCH: if (wr_valid) begin
               if (wr_bit != cur_bit) begin
                  st_nxt  = ST_PARK;
                  ptr_clr = 1'b1;
               end else if (ptr_last) begin
                  ptr_clr = 1'b1;
                  st_nxt  = ST_SEL;
                  go_sel  = 1'b1;
               end else begin
                  ptr_adv = 1'b1;
               end
            end
            ST_SRCH_T: if (rd_done) st_nxt = ST_SRCH_C;
            ST_SRCH_C: if (rd_done) st_nxt = ST_SRCH_W;
            ST_SRCH_W: if (wr_valid) begin
               if (wr_bit != cur_bit) begin
                  st_nxt  = ST_PARK;
                  ptr_clr = 1'b1;
               end else if (ptr_last) begin
                  ptr_clr = 1'b1;
                  st_nxt  = ST_SEL;
                  go_sel  = 1'b1;
               end else begin
                  ptr_adv = 1'b1;
                  st_nxt  = ST_SRCH_T;
               end
            end
            ST_SEL:  st_nxt = ST_SEL;
            ST_PARK: st_nxt = ST_PARK;
            default: st_nxt = ST_PARK;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_CMD;
         cmd_sr  <= '0;
         handoff <= 1'b0;
      end else begin
         st      <= st_nxt;
         handoff <= go_sel;
         if (st == ST_CMD && wr_valid && !lnk_reset)
            cmd_sr <= {wr_bit, cmd_sr[CMD_W-2:1]};
      end
   end

   logic talking;
   assign talking  = (st == ST_READ) || (st == ST_SRCH_T) || (st == ST_SRCH_C);
   assign tx_en    = talking;
   assign tx_bit   = !talking ? 1'b1 : ((st == ST_SRCH_C) ? ~cur_bit : cur_bit);
   assign selected = (st == ST_SEL);
endmodule

// File: rtl/netaddr_sel_checker.sv
module netaddr_sel_checker (
   input logic clk,
   input logic rst_n,
   input logic lnk_reset,
   input logic tx_en,
   input logic tx_bit,
   input logic selected,
   input logic handoff
);
   p_reset_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      lnk_reset |=> (!tx_en && !selected && !handoff))
      else $error("p_reset_quiet_r10");

   p_handoff_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
      handoff |=> !handoff)
      else $error("p_handoff_once_r11");

   p_handoff_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
      handoff |-> selected)
      else $error("p_handoff_sel_r11");

   p_sel_rise_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(selected) |-> handoff)
      else $error("p_sel_rise_strobe_r4");

   p_sel_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (selected && !lnk_reset) |=> selected)
      else $error("p_sel_hold_r6");

   p_no_talk_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
      selected |-> !tx_en)
      else $error("p_no_talk_sel_r3");

   p_release_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |-> tx_bit)
      else $error("p_release_idle_r8");
endmodule

bind onewire_netaddr_sel netaddr_sel_checker u_chk (.*);

// File: tb/onewire_netaddr_sel_bench.sv
module onewire_netaddr_sel_bench;
   localparam int CLK_PERIOD = 10;
   localparam int SER_W      = 48;
   localparam int WATCHDOG   = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lnk_reset = 1'b0, wr_valid = 1'b0, wr_bit = 1'b0, rd_done = 1'b0;
   logic [SER_W-1:0] serial_no = '0;
   logic tx_en, tx_bit, selected, handoff;

   int checks = 0, errors = 0, cyc = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   onewire_netaddr_sel u_onewire_netaddr_sel (
      .clk, .rst_n, .lnk_reset, .wr_valid, .wr_bit, .rd_done,
      .serial_no, .tx_en, .tx_bit, .selected, .handoff
   );

   function automatic logic [7:0] crc_of(input logic [55:0] d);
      logic [7:0] c = 8'h00;
      for (int i = 0; i < 56; i++) begin
         logic fb = c[0] ^ d[i];
         c = c >> 1;
         if (fb) c = c ^ 8'h8C;
      end
      return c;
   endfunction

   function automatic logic [63:0] make_id(input logic [SER_W-1:0] s);
      logic [55:0] body = {s, 8'h09};
      return {crc_of(body), body};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic put_bit(input logic b);
      wr_valid = 1'b1; wr_bit = b;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic put_byte(input logic [7:0] v);
      for (int i = 0; i < 8; i++) put_bit(v[i]);
   endtask

   task automatic get_bit(output logic b, output logic en);
      b = tx_bit; en = tx_en;
      rd_done = 1'b1;
      @(negedge clk);
      rd_done = 1'b0;
   endtask

   task automatic bus_reset();
      lnk_reset = 1'b1;
      @(negedge clk);
      lnk_reset = 1'b0;
   endtask

   task automatic run_read(input logic [7:0] opc, input logic [63:0] id, input string tag);
      logic [63:0] got;
      logic b, en;
      bit en_ok = 1;
      bus_reset();
      put_byte(opc);
      for (int i = 0; i < 64; i++) begin
         get_bit(b, en);
         got[i] = b;
         if (!en) en_ok = 0;
      end
      chk(en_ok, {tag, " R3 tx_en during read"}, 64'(en_ok), 1);
      chk(got == id, {tag, " R3 identity bits"}, got, id);
      chk(got[7:0] == 8'h09, {tag, " R2 family code"}, 64'(got[7:0]), 64'h09);
      chk(got[63:56] == crc_of(got[55:0]), {tag, " R2 stored crc"}, 64'(got[63:56]), 64'(crc_of(got[55:0])));
      chk(selected && handoff, {tag, " R3 R11 selected with strobe"}, {selected, handoff}, 2'b11);
      @(negedge clk);
      chk(selected && !handoff, {tag, " R11 strobe one cycle"}, {selected, handoff}, 2'b10);
   endtask

   task automatic run_match(input logic [63:0] id, input int bad, input string tag);
      bus_reset();
      put_byte(8'h55);
      for (int i = 0; i < 64; i++) put_bit((i == bad) ? ~id[i] : id[i]);
      if (bad < 0) begin
         chk(selected && handoff, {tag, " R4 match selects"}, {selected, handoff}, 2'b11);
      end else begin
         chk(!selected && !handoff && !tx_en, {tag, " R5 mismatch parks"}, {selected, handoff, tx_en}, 0);
         put_byte(8'hCC);
         chk(!selected && !tx_en, {tag, " R5 ignores later bits"}, {selected, tx_en}, 0);
      end
   endtask

   task automatic run_search(input logic [63:0] id, input int bad, input string tag);
      logic t, c, et, ec;
      bit seq_ok = 1, quiet_ok = 1;
      bus_reset();
      put_byte(8'hF0);
      for (int i = 0; i < 64; i++) begin
         get_bit(t, et);
         get_bit(c, ec);
         if (i <= bad || bad < 0) begin
            if (!(et && ec && t == id[i] && c == ~id[i])) seq_ok = 0;
         end else if (et || ec || selected) quiet_ok = 0;
         put_bit((i == bad) ? ~id[i] : id[i]);
      end
      chk(seq_ok, {tag, " R7 true then complement"}, 64'(seq_ok), 1);
      if (bad < 0) begin
         chk(selected && handoff, {tag, " R7 search selects"}, {selected, handoff}, 2'b11);
      end else begin
         chk(quiet_ok, {tag, " R8 silent after dropout"}, 64'(quiet_ok), 1);
         chk(!selected && !tx_en, {tag, " R8 no selection"}, {selected, tx_en}, 0);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > WATCHDOG && !finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [SER_W-1:0] sers [3];
      sers[0] = 48'h0000_0000_0001;
      sers[1] = 48'hA5C3_9E17_42F0;
      sers[2] = 48'hFFFF_FFFF_FFFF;
      repeat (3) @(negedge clk);
      chk(!tx_en && !selected && !handoff, "R1 reset outputs", {tx_en, selected, handoff}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!tx_en && !selected && !handoff, "R1 after release", {tx_en, selected, handoff}, 0);

      for (int s = 0; s < 3; s++) begin
         logic [63:0] id;
         serial_no = sers[s];
         id = make_id(sers[s]);
         run_read(8'h33, id, $sformatf("s%0d", s));
         run_match(id, -1, $sformatf("s%0d", s));
         for (int k = 0; k < 64; k += 21) run_match(id, k, $sformatf("s%0d bad%0d", s, k));
         run_search(id, -1, $sformatf("s%0d", s));
         for (int k = 0; k < 64; k += 31) run_search(id, k, $sformatf("s%0d drop%0d", s, k));
         bus_reset();
         put_byte(8'hCC);
         chk(selected && handoff, $sformatf("s%0d R6 skip selects", s), {selected, handoff}, 2'b11);
      end

      run_read(8'h39, make_id(sers[2]), "alt");

      bus_reset();
      put_byte(8'hA5);
      chk(!selected && !tx_en, "R9 unknown parks", {selected, tx_en}, 0);
      put_byte(8'hCC);
      chk(!selected && !tx_en, "R9 skip ignored while parked", {selected, tx_en}, 0);

      begin
         logic [63:0] id = make_id(sers[2]);
         bus_reset();
         put_byte(8'h55);
         for (int i = 0; i < 63; i++) put_bit(id[i]);
         lnk_reset = 1'b1;
         put_bit(id[63]);
         lnk_reset = 1'b0;
         chk(!selected && !handoff, "R10 reset beats last bit", {selected, handoff}, 0);
         put_byte(8'hCC);
         chk(selected && handoff, "R10 fresh command after collision", {selected, handoff}, 2'b11);
         bus_reset();
         chk(!selected && !tx_en, "R10 reset clears selection", {selected, tx_en}, 0);
         put_byte(8'h33);
         chk(tx_en && tx_bit == id[0], "R10 command accepted after reset", {tx_en, tx_bit}, {1'b1, id[0]});
      end

      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule